// File: doc/BRIEF.md
# Reload-Counter Serial Baud Generator

This block produces the bit-rate timing for a serial line controller. A down-counting reload counter divides a source clock. The source is either the block's own clock or an external clock input. Each time the counter passes through zero it reloads and emits a single-cycle tick that the shift logic uses to advance one bit. Alongside the tick the block drives a square-ish serial clock waveform with the same period.

Software programs the divider through a 16-bit configuration register. The top bit picks the external clock as the count source. The lower fifteen bits hold the reload value. The register only changes on a full-width write. A new reload value is normally picked up at the next wrap through zero, so a bit period that is already running is not cut short. Pulsing the programmable-clear input restarts the counter at once from the present register contents.

Top module: `baud_reload_gen`

## Requirements
- R1: After reset `cfg_q` reads 0, `ser_clk` is high and `baud_tick` is low.
- R2: A write updates the register only when `wr_en` is high and both byte enables are set. Any write with `wr_be` other than 2'b11 leaves `cfg_q` and the tick period unchanged.
- R3: With reload value R (bits 14:0) and the internal source, `baud_tick` is high for one cycle every R+1 clock cycles. Each tick marks a reload of the counter.
- R4: Changing R while the counter runs does not disturb the period in progress. The next tick comes on the old schedule, and the new R governs the periods after it.
- R5: A one-cycle pulse on `prog_clr` reloads the counter from the current R. It produces no tick itself, and the first tick follows R+1 counts after the clear.
- R6: `ser_clk` goes low at each reload and goes high floor((R+1)/2) counts later. It is therefore low for floor((R+1)/2) counts and high for the remaining counts of the R+1 period, so an even R gives a high half one count longer than the low half.
- R7: With R = 0, `baud_tick` is high on every enabled count and `ser_clk` stays low.
- R8: With bit 15 set, the counter advances only once per rising edge of `ext_clk`, seen after a two-flop synchronizer. With `ext_clk` held still, no tick occurs.
- R9: `cfg_q` always shows the value last written by a full-width write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the internal count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables; the write applies only when both are set |
| wr_data | input | 16 | Write data: bit 15 selects the external source, bits 14:0 hold the reload value |
| prog_clr | input | 1 | Programmable clear; reloads the counter immediately |
| ext_clk | input | 1 | External count clock, asynchronous to `clk` |
| cfg_q | output | 16 | Current register contents |
| ser_clk | output | 1 | Serial clock waveform |
| baud_tick | output | 1 | One-cycle pulse at each counter reload |

## Verification
The hardest case to reach from the ports is a register change in the middle of a running period. Only the tick timing shows whether the counter kept its old count. The stimulus clears the counter with a long reload value, then writes a short value a few cycles later without a clear. It then measures the distance to the next tick and the tick after that separately. The external-source case needs a slow toggling `ext_clk` with a known period, so that the tick interval becomes an exact multiple of that period.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned CFG_W = 16;

  // number of counts after a reload at which the serial clock rises
  function automatic logic [31:0] rise_after(input logic [31:0] rld);
    return (rld + 32'd1) >> 1;
  endfunction

  // counter value at which the rising edge is scheduled
  function automatic logic [31:0] rise_count(input logic [31:0] rld);
    return rld - rise_after(rld) + 32'd1;
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int unsigned DW = 16,
  localparam int unsigned BE_W = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BE_W-1:0] wr_be,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   cfg_q,
  output logic            ext_sel,
  output logic [DW-2:0]   reload_val
);
  logic full_wr;
  assign full_wr = wr_en && (&wr_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (full_wr) cfg_q <= wr_data;
  end

  assign ext_sel    = cfg_q[DW-1];
  assign reload_val = cfg_q[DW-2:0];

  // R2
  partial_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&wr_be)) |=> $stable(cfg_q));
endmodule

// File: rtl/baud_src_sel.sv
module baud_src_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic ext_clk,
  output logic count_en
);
  logic [SYNC_STAGES:0] sync_sh;
  logic                 ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= {sync_sh[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = sync_sh[SYNC_STAGES-1] && !sync_sh[SYNC_STAGES];
  assign count_en = ext_sel ? ext_rise : 1'b1;

  // R8
  ext_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && count_en) |=> !(ext_sel && count_en));
endmodule

// File: rtl/baud_reload_ctr.sv
module baud_reload_ctr
  import baud_pkg::*;
#(
  parameter int unsigned RW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_en,
  input  logic          prog_clr,
  input  logic [RW-1:0] reload_val,
  output logic          ser_clk,
  output logic          baud_tick
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] act_rld_q;
  logic [RW-1:0] rise_at;
  logic          wrap_evt;
  logic          mid_evt;

  assign rise_at  = RW'(rise_count(32'(act_rld_q)));
  assign wrap_evt = count_en && (cnt_q == '0) && !prog_clr;
  assign mid_evt  = count_en && (cnt_q != '0) && (cnt_q == rise_at) && !prog_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_rld_q <= '0;
      ser_clk   <= 1'b1;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= wrap_evt;
      if (prog_clr || wrap_evt) begin
        cnt_q     <= reload_val;
        act_rld_q <= reload_val;
        ser_clk   <= 1'b0;
      end else if (count_en) begin
        cnt_q <= cnt_q - 1'b1;
        if (mid_evt) ser_clk <= 1'b1;
      end
    end
  end

  // R5
  clr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_clr |=> (cnt_q == $past(reload_val)) && !baud_tick);
  // R4
  no_early_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && (cnt_q != '0) && !prog_clr) |=>
      (cnt_q == $past(cnt_q) - 1'b1) && $stable(act_rld_q));
  // R3
  tick_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> ($past(cnt_q) == '0) && $past(count_en));
  // R6
  low_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !ser_clk);
endmodule

// File: rtl/baud_reload_gen.sv
module baud_reload_gen
  import baud_pkg::*;
#(
  parameter int unsigned DW = CFG_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RW = DW - 1,
  localparam int unsigned BE_W = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BE_W-1:0] wr_be,
  input  logic [DW-1:0]   wr_data,
  input  logic            prog_clr,
  input  logic            ext_clk,
  output logic [DW-1:0]   cfg_q,
  output logic            ser_clk,
  output logic            baud_tick
);
  logic          ext_sel;
  logic [RW-1:0] reload_val;
  logic          count_en;

  baud_cfg_reg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .cfg_q(cfg_q), .ext_sel(ext_sel), .reload_val(reload_val)
  );

  baud_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .ext_clk(ext_clk),
    .count_en(count_en)
  );

  baud_reload_ctr #(.RW(RW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .prog_clr(prog_clr),
    .reload_val(reload_val), .ser_clk(ser_clk), .baud_tick(baud_tick)
  );
endmodule

// File: tb/baud_reload_gen_bench.sv
module baud_reload_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic        prog_clr = 1'b0;
  logic        ext_clk = 1'b0;
  logic        ext_run = 1'b0;
  logic [15:0] cfg_q;
  logic        ser_clk;
  logic        baud_tick;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  baud_reload_gen u_baud_reload_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .prog_clr(prog_clr), .ext_clk(ext_clk), .cfg_q(cfg_q),
    .ser_clk(ser_clk), .baud_tick(baud_tick)
  );

  // external clock: toggles every 4 cycles, so one rising edge per 8 cycles
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      if (ext_run) ext_clk = ~ext_clk;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic pulse_clr();
    prog_clr = 1'b1;
    @(negedge clk);
    prog_clr = 1'b0;
  endtask

  task automatic cycles_to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick && n < 2000);
  endtask

  function automatic int low_len(input int r);
    return (r + 1) / 2;
  endfunction

  task automatic test_reset();
    check("R1 cfg", int'(cfg_q), 0);
    check("R1 ser_clk", int'(ser_clk), 1);
    check("R1 tick", int'(baud_tick), 0);
  endtask

  task automatic test_period(input int r);
    int n;
    reg_write(2'b11, 16'(r));
    check("R9 readback", int'(cfg_q), r);
    pulse_clr();
    cycles_to_tick(n);
    check("R5 first tick after clear", n, r + 1);
    cycles_to_tick(n);
    check("R3 period", n, r + 1);
  endtask

  task automatic test_partial_write();
    int n;
    reg_write(2'b11, 16'd9);
    pulse_clr();
    reg_write(2'b01, 16'd3);
    reg_write(2'b10, 16'd3);
    check("R2 cfg after byte writes", int'(cfg_q), 9);
    cycles_to_tick(n);
    cycles_to_tick(n);
    check("R2 period after byte writes", n, 10);
  endtask

  task automatic test_duty(input int r);
    int lo;
    int hi;
    int n;
    reg_write(2'b11, 16'(r));
    pulse_clr();
    cycles_to_tick(n);
    lo = 1;
    @(negedge clk);
    while (!ser_clk && lo < 2000) begin lo++; @(negedge clk); end
    hi = 0;
    while (ser_clk && hi < 2000) begin hi++; @(negedge clk); end
    check("R6 low length", lo, low_len(r));
    check("R6 high length", hi, r + 1 - low_len(r));
  endtask

  task automatic test_deferred();
    int n;
    reg_write(2'b11, 16'd20);
    pulse_clr();
    repeat (2) @(negedge clk);
    reg_write(2'b11, 16'd5);
    cycles_to_tick(n);
    check("R4 running period kept", n + 3, 21);
    cycles_to_tick(n);
    check("R4 new value next period", n, 6);
  endtask

  task automatic test_clear_now();
    int n;
    reg_write(2'b11, 16'd30);
    pulse_clr();
    repeat (5) @(negedge clk);
    reg_write(2'b11, 16'd3);
    pulse_clr();
    cycles_to_tick(n);
    check("R5 immediate reload", n, 4);
  endtask

  task automatic test_zero();
    int hits;
    int lows;
    int n;
    reg_write(2'b11, 16'd0);
    pulse_clr();
    cycles_to_tick(n);
    hits = 0;
    lows = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (baud_tick) hits++;
      if (!ser_clk) lows++;
    end
    check("R7 tick every cycle", hits, 6);
    check("R7 ser_clk low", lows, 6);
  endtask

  task automatic test_external();
    int n;
    int seen;
    reg_write(2'b11, 16'h8002);
    pulse_clr();
    ext_run = 1'b1;
    cycles_to_tick(n);
    cycles_to_tick(n);
    check("R8 external period", n, 24);
    cycles_to_tick(n);
    check("R8 external period again", n, 24);
    ext_run = 1'b0;
    repeat (10) @(negedge clk);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (baud_tick) seen++;
    end
    check("R8 no tick with idle ext_clk", seen, 0);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_period(9);
    test_period(1);
    test_partial_write();
    test_duty(4);
    test_duty(5);
    test_duty(2);
    test_deferred();
    test_clear_now();
    test_zero();
    test_external();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule